// File: doc/BRIEF.md
# UART Receive Character Buffer

This block holds received characters for a UART until software reads them. With the buffer mode enabled it is a 16-entry circular queue. With the mode disabled it is a single holding register. Each stored entry carries the character in its low 8 bits and four error flags above it. The flags are framing error, parity error, break and overrun.

Characters come from the line receiver or, when loopback is selected, from the transmit data path. A line-break event is stored as an entry of its own. A read pops the head entry and copies that entry's error flags into a status register.

The block drives the full and empty flags and a ready signal for the receiver. It also drives a receive interrupt bit. That bit is raised when the fill level rises to the trigger level and dropped when it falls back below it. Any change of the buffer mode empties the buffer.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset the buffer is empty (`empty`=1, `full`=0, `rx_ready`=1), `rx_irq`=0, `err_status`=0, and the buffer mode is disabled.
- R2: With the buffer mode enabled, up to 16 entries are held and read back in arrival order, with indices wrapping. `full` rises on the 16th entry, and `rx_ready` is low exactly while `full` is high.
- R3: With the buffer mode disabled, one entry fills the buffer: `full`=1 and `rx_ready`=0 after a single push.
- R4: `rd_data` always shows the head entry. A pop on an empty buffer leaves the flags and the head unchanged, so `rd_data` keeps showing the stale head entry.
- R5: With trigger level 1, `rx_irq` is set when a push takes the count from 0 to 1. It is cleared when a pop takes the count from 1 to 0. A push and a pop in the same cycle at count 1 leave it unchanged.
- R6: Every read (`rd_en` high) loads `err_status` from bits [11:8] of the entry shown on `rd_data`. The status bits are: bit 0 framing, bit 1 parity, bit 2 break, bit 3 overrun. A receiver entry stores `rx_flags` (bit 0 framing, bit 1 parity) in entry bits [9:8].
- R7: A push while full with no pop in the same cycle is dropped, and it sets the overrun bit (bit 11) of the most recently stored entry.
- R8: `rx_break` stores an entry with data 0 and the break bit (bit 10) set. It takes precedence over `rx_valid` in the same cycle, and that receiver character is dropped.
- R9: With `loopback`=1, `rx_valid` and `rx_break` are ignored and `tx_valid` stores `tx_data` with clear error bits. With `loopback`=0, `tx_valid` is ignored.
- R10: A change of `fifo_en` empties the buffer and clears `rx_irq` at the next clock edge. Pushes and reads presented in that cycle are ignored.
- R11: A push and a pop in the same cycle while full are both accepted, and the buffer stays full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1 selects 16-entry buffer mode, 0 selects a single holding register |
| loopback | input | 1 | Take characters from the transmit path instead of the receiver |
| rx_valid | input | 1 | Receiver presents a character |
| rx_data | input | 8 | Received character |
| rx_flags | input | 2 | Receiver errors: bit 0 framing, bit 1 parity |
| rx_break | input | 1 | Line-break event |
| tx_valid | input | 1 | Transmit data written (used in loopback) |
| tx_data | input | 8 | Transmit character |
| rd_en | input | 1 | Software read: pop the head entry |
| rd_data | output | 12 | Head entry: {overrun, break, parity, framing, data[7:0]} |
| err_status | output | 4 | Error flags of the last entry read |
| rx_ready | output | 1 | Buffer can accept a character |
| empty | output | 1 | Buffer empty |
| full | output | 1 | Buffer full |
| rx_irq | output | 1 | Receive interrupt status bit |

## Verification
A head pointer that drifts shows up on `rd_data` at once, as a character out of arrival order. A wrong count shows up one cycle later as `full`, `empty` or `rx_ready` disagreeing with the number of pushes minus pops. A count that is wrong at the 0/1 boundary also leaves `rx_irq` wrongly set or clear. A bad write slot or a bad tail index corrupts only a later entry, so the fill, wrap and overrun sequences read every entry back. A missed flush on a mode change is visible in the very next cycle on `empty`.

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int TRIG  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          loopback,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic [1:0]    rx_flags,
  input  logic          rx_break,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_data,
  input  logic          rd_en,
  output logic [DW+3:0] rd_data,
  output logic [3:0]    err_status,
  output logic          rx_ready,
  output logic          empty,
  output logic          full,
  output logic          rx_irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int EW = DW + 4;

  logic          mode_q;
  logic [AW-1:0] head;
  logic [CW-1:0] count;
  logic [EW-1:0] mem [DEPTH];

  logic          flush, push_req, pop, accept, ovr;
  logic [AW-1:0] mask, wr_slot, tail;
  logic [CW-1:0] lim, next_count;
  logic [EW-1:0] push_ent;

  assign flush    = fifo_en != mode_q;
  assign mask     = mode_q ? AW'(DEPTH - 1) : '0;
  assign lim      = mode_q ? CW'(DEPTH) : CW'(1);
  assign full     = count == lim;
  assign empty    = count == '0;
  assign rx_ready = !full;
  assign rd_data  = mem[head];

  assign push_req = loopback ? tx_valid : (rx_valid | rx_break);
  assign push_ent = loopback ? {4'b0000, tx_data}
                  : rx_break ? {4'b0100, {DW{1'b0}}}
                  : {2'b00, rx_flags, rx_data};

  assign pop        = rd_en && !empty && !flush;
  assign accept     = push_req && !flush && (!full || pop);
  assign ovr        = push_req && !flush && full && !pop;
  assign wr_slot    = (head + count[AW-1:0]) & mask;
  assign tail       = (head + count[AW-1:0] - AW'(1)) & mask;
  assign next_count = count + CW'(accept) - CW'(pop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= 1'b0;
      head       <= '0;
      count      <= '0;
      rx_irq     <= 1'b0;
      err_status <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (flush) begin
      mode_q <= fifo_en;
      head   <= '0;
      count  <= '0;
      rx_irq <= 1'b0;
    end else begin
      if (rd_en) err_status <= rd_data[EW-1:DW];
      if (pop) head <= (head + AW'(1)) & mask;
      if (accept) mem[wr_slot] <= push_ent;
      if (ovr) mem[tail][EW-1] <= 1'b1;
      count <= next_count;
      if (next_count == CW'(TRIG) && count == CW'(TRIG - 1))
        rx_irq <= 1'b1;
      else if (next_count == CW'(TRIG - 1) && count == CW'(TRIG))
        rx_irq <= 1'b0;
    end
  end
endmodule

module uart_rx_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5,
  parameter int EW    = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_en,
  input logic          mode_q,
  input logic          rx_valid,
  input logic          rx_break,
  input logic          tx_valid,
  input logic          rd_en,
  input logic [EW-1:0] rd_data,
  input logic [3:0]    err_status,
  input logic          empty,
  input logic          full,
  input logic          rx_irq,
  input logic [CW-1:0] count
);
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (mode_q ? CW'(DEPTH) : CW'(1)));

  assert_stale_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty && !rx_valid && !rx_break && !tx_valid && fifo_en == mode_q)
    |=> (empty && $stable(rd_data)));

  assert_irq_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq) |-> ($past(empty) && !empty));

  assert_irq_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_irq) |-> empty);

  assert_status_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(err_status));

  assert_full_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_en && fifo_en == mode_q) |=> full);
endmodule

bind uart_rx_fifo uart_rx_fifo_chk #(.DEPTH(DEPTH), .CW(CW), .EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .mode_q(mode_q),
  .rx_valid(rx_valid), .rx_break(rx_break), .tx_valid(tx_valid),
  .rd_en(rd_en), .rd_data(rd_data), .err_status(err_status),
  .empty(empty), .full(full), .rx_irq(rx_irq), .count(count)
);

// File: tb/sim_uart_rx_fifo.sv
module sim_uart_rx_fifo;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 1'b0, loopback = 1'b0;
  logic rx_valid = 1'b0, rx_break = 1'b0, tx_valid = 1'b0, rd_en = 1'b0;
  logic [7:0] rx_data = '0, tx_data = '0;
  logic [1:0] rx_flags = '0;
  logic [11:0] rd_data;
  logic [3:0] err_status;
  logic rx_ready, empty, full, rx_irq;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  uart_rx_fifo u0 (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .loopback(loopback),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_flags(rx_flags), .rx_break(rx_break),
    .tx_valid(tx_valid), .tx_data(tx_data), .rd_en(rd_en), .rd_data(rd_data),
    .err_status(err_status), .rx_ready(rx_ready), .empty(empty), .full(full),
    .rx_irq(rx_irq)
  );

  // {push, data[7:0], pop, exp_empty, exp_full, exp_irq, exp_head[7:0]}
  localparam logic [20:0] VEC [7] = '{
    {1'b1, 8'h11, 1'b0, 1'b0, 1'b0, 1'b1, 8'h11},
    {1'b1, 8'h22, 1'b0, 1'b0, 1'b0, 1'b1, 8'h11},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 8'h22},
    {1'b1, 8'h33, 1'b1, 1'b0, 1'b0, 1'b1, 8'h33},
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00},
    {1'b1, 8'h44, 1'b1, 1'b0, 1'b0, 1'b1, 8'h44},
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d, input logic [1:0] f);
    rx_valid = 1'b1; rx_data = d; rx_flags = f;
    cyc;
    rx_valid = 1'b0; rx_flags = '0;
  endtask

  task automatic pop;
    rd_en = 1'b1;
    cyc;
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [11:0] hold;
    @(negedge clk);
    repeat (2) cyc;
    chk("R1 empty", empty, 1); chk("R1 full", full, 0); chk("R1 ready", rx_ready, 1);
    chk("R1 irq", rx_irq, 0); chk("R1 status", err_status, 0);
    rst_n = 1'b1;
    fifo_en = 1'b1;
    cyc;
    chk("R10 flush on enable", empty, 1);

    // table walk, R2/R4/R5
    for (int i = 0; i < 7; i++) begin
      rx_valid = VEC[i][20]; rx_data = VEC[i][19:12]; rd_en = VEC[i][11];
      cyc;
      rx_valid = 1'b0; rd_en = 1'b0;
      chk($sformatf("R5 vec%0d empty/full/irq", i), {empty, full, rx_irq}, VEC[i][10:8]);
      chk($sformatf("R4 vec%0d head", i), rd_data, {4'h0, VEC[i][7:0]});
    end

    // fill to 16 with wrap, R2
    for (int i = 0; i < 15; i++) push(8'h40 + 8'(i), 2'b00);
    chk("R2 not full at 15", {full, rx_ready}, 2'b01);
    push(8'h4F, 2'b00);
    chk("R2 full at 16", {full, rx_ready}, 2'b10);
    push(8'hEE, 2'b00);
    chk("R7 still full after overrun", full, 1);
    chk("R4 head before pop", rd_data, 12'h040);
    rx_valid = 1'b1; rx_data = 8'h99; rd_en = 1'b1;
    cyc;
    rx_valid = 1'b0; rd_en = 1'b0;
    chk("R11 full after push+pop", full, 1);
    for (int i = 1; i < 16; i++) begin
      chk($sformatf("R2 order %0d", i), rd_data, (i == 15) ? 12'h84F : 12'h040 + 12'(i));
      pop;
    end
    chk("R7 overrun status", err_status, 4'b1000);
    chk("R11 pushed entry", rd_data, 12'h099);
    pop;
    chk("R5 irq cleared", {empty, rx_irq}, 2'b10);

    // error flags, R6
    push(8'h5A, 2'b01);
    chk("R6 framing entry", rd_data, 12'h15A);
    pop;
    chk("R6 framing status", err_status, 4'b0001);
    push(8'hA5, 2'b10);
    pop;
    chk("R6 parity status", err_status, 4'b0010);

    // break precedence, R8
    rx_break = 1'b1; rx_valid = 1'b1; rx_data = 8'h66;
    cyc;
    rx_break = 1'b0; rx_valid = 1'b0;
    chk("R8 break entry", rd_data, 12'h400);
    pop;
    chk("R8 break status", err_status, 4'b0100);
    chk("R8 rx char dropped", empty, 1);

    // loopback, R9
    loopback = 1'b1;
    push(8'h77, 2'b00);
    rx_break = 1'b1; cyc; rx_break = 1'b0;
    chk("R9 external ignored", empty, 1);
    tx_valid = 1'b1; tx_data = 8'h3C; cyc; tx_valid = 1'b0;
    chk("R9 tx looped", {empty, rd_data}, {1'b0, 12'h03C});
    pop;
    loopback = 1'b0;
    tx_valid = 1'b1; tx_data = 8'hC3; cyc; tx_valid = 1'b0;
    chk("R9 tx ignored without loopback", empty, 1);

    // stale pop, R4
    hold = rd_data;
    pop;
    chk("R4 stale pop", {empty, rd_data}, {1'b1, hold});

    // mode change flush, R10
    push(8'h01, 2'b00);
    push(8'h02, 2'b00);
    fifo_en = 1'b0;
    cyc;
    chk("R10 flush", {empty, full, rx_irq}, 3'b100);

    // single register mode, R3
    push(8'h12, 2'b00);
    chk("R3 full after one", {full, rx_ready, rx_irq}, 3'b101);
    push(8'h34, 2'b00);
    chk("R7 single overrun", rd_data, 12'h812);
    pop;
    chk("R3 empty after pop", {empty, full}, 2'b10);
    chk("R6 single overrun status", err_status, 4'b1000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule